// File: doc/BRIEF.md
# Packed-Word NTT Sequencer

This block carries out a complete in-place number-theoretic transform of a 256-coefficient polynomial over the prime field of 7681. The polynomial sits in an external single-port RAM in which every 28-bit word holds two 14-bit coefficients. The block owns one modular multiplier and one butterfly unit. It steps through every stage of the transform, generating RAM addresses, read and write strobes and twiddle-factor exponents. The caller loads the RAM, pulses `start`, waits for `done` and then reads the result back.

The first stage pairs the two halves of a word, so each word is read, transformed and written back in place. In every later stage the butterfly partners lie in different words. The block therefore fetches two words whose lanes line up, runs two butterflies and writes the two words back repacked: the results of each butterfly share one word. This keeps the partners of the next stage lane-aligned, so each stage reads and writes every word exactly once.

The input polynomial is expected in bit-reversed order. Bit reversal and any inverse-transform scaling belong to the caller. The RAM port has a fixed one-cycle read latency and no back-pressure. No data stream crosses the block's edge, so it has no valid/ready handshake. `start`, `busy` and `done` are plain level and pulse signals.

Top module: `ntt_packed_core`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `done`, `mem_rd_en` and `mem_wr_en` are all low.
- R2: A `start` seen in a cycle where `busy` is low makes `busy` high from the next cycle on, and that first busy cycle reads word 0. A `start` seen while `busy` is high has no effect on the run's length, its memory traffic or its result.
- R3: `mem_rd_en` and `mem_wr_en` are never high together, and neither is high while `busy` is low.
- R4: Stage one visits words 0 to 127 in ascending order. Each word is read, then written back to the same address two cycles later. A word holding x in bits [13:0] and y in bits [27:14] becomes (x+y) mod q in bits [13:0] and (x−y) mod q in bits [27:14].
- R5: Every later stage handles word pairs with two reads, two compute cycles and two writes. The writes go to the two read addresses in read order, and each lands four cycles after the matching read. The two addresses of a pair differ in address bit s−2 for stage s (s = 2..8). Stage 2 therefore starts with words 0 and 1, stage 3 with words 0 and 2, and the last pair of stage 8 is words 63 and 127.
- R6: For a pair read as first word (a in [13:0], b in [27:14]) and second word (c, d), the first word is written back as (a+w·c, a−w·c) and the second as (b+w'·d, b−w'·d), where w' = w·ω^64. Each word takes the sum in [13:0] and the difference in [27:14]. In stage 2 the first pair uses w = 1.
- R7: Every 14-bit field written to memory lies in [0, q−1] when all input fields do.
- R8: Storage index i means bit i&1 of word i>>1. If storage index i holds p[bitrev8(i)], then after the run word k holds X[k] in bits [13:0] and X[k+128] in bits [27:14]. Here X[k] = Σ p[j]·ω^(jk) mod 7681, and ω = g^30 mod 7681 for the smallest g ≥ 2 whose power has ω^128 = 7680.
- R9: `done` is high exactly 3072 clock edges after the edge that accepts `start`, which is one cycle after the final write.
- R10: A run issues exactly 1024 reads and 1024 writes: each of the eight stages touches every word once.
- R11: `done` is a single-cycle pulse, and `busy` is low in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform; accepted only while idle |
| busy | output | 1 | High while a transform is in progress |
| done | output | 1 | One-cycle pulse after the final write |
| mem_rd_en | output | 1 | RAM read strobe; data returns the next cycle |
| mem_wr_en | output | 1 | RAM write strobe |
| mem_addr | output | 7 | RAM word address for read or write |
| mem_wdata | output | 28 | Write word: bits [13:0] lane 0, bits [27:14] lane 1 |
| mem_rdata | input | 28 | Read word, valid the cycle after mem_rd_en |

## Verification
An all-zero polynomial shows that nothing leaks into the data path. A lone coefficient at storage index 0 must spread to a flat all-ones spectrum, while a lone coefficient at storage index 1 must give an alternating ±1 spectrum; together they separate correct twiddle ordering from lane or address mix-ups. An all-(q−1) input drives every sum and difference across its reduction boundary. Random polynomials, one of them with a stray `start` pulse mid-run, are compared in full against a direct O(n²) transform after the final packing is undone, and the logged addresses and first written words pin down the stage-one, stage-two and repacking rules.

// File: rtl/ntt_pkg.sv
package ntt_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RD0,
    PH_RD1,
    PH_BF0,
    PH_BF1,
    PH_WR0,
    PH_WR1
  } phase_e;

  function automatic longint unsigned mod_mul(longint unsigned a, longint unsigned b,
                                              longint unsigned q);
    return (a * b) % q;
  endfunction

  function automatic longint unsigned mod_pow(longint unsigned b, longint unsigned e,
                                              longint unsigned q);
    longint unsigned r;
    longint unsigned x;
    longint unsigned ee;
    r  = 1;
    x  = b % q;
    ee = e;
    while (ee != 0) begin
      if ((ee & 1) != 0) r = mod_mul(r, x, q);
      x  = mod_mul(x, x, q);
      ee = ee >> 1;
    end
    return r;
  endfunction

  // Smallest-candidate element of exact order n (n a power of two dividing q-1).
  function automatic longint unsigned root_of_unity(longint unsigned n, longint unsigned q);
    longint unsigned r;
    longint unsigned x;
    r = 0;
    for (longint unsigned g = 2; g < q && r == 0; g++) begin
      x = mod_pow(g, (q - 1) / n, q);
      if (mod_pow(x, n / 2, q) == q - 1) r = x;
    end
    return r;
  endfunction

endpackage

// File: rtl/ntt_twiddle_rom.sv
module ntt_twiddle_rom #(
  parameter int unsigned N  = 256,
  parameter int unsigned Q  = 7681,
  parameter int unsigned QW = 14,
  parameter int unsigned EW = 7
) (
  input  logic [EW-1:0] idx,
  output logic [QW-1:0] w
);
  localparam longint unsigned OMEGA   = ntt_pkg::root_of_unity(N, Q);
  localparam int unsigned     ENTRIES = N / 2;

  logic [QW-1:0] tbl [ENTRIES];

  // Each entry is a constant power of the root, folded at elaboration.
  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    localparam longint unsigned VAL = ntt_pkg::mod_pow(OMEGA, i, Q);
    assign tbl[i] = QW'(VAL);
  end

  assign w = tbl[idx];
endmodule

// File: rtl/ntt_modmul.sv
module ntt_modmul #(
  parameter int unsigned Q  = 7681,
  parameter int unsigned QW = 14
) (
  input  logic [QW-1:0] a,
  input  logic [QW-1:0] b,
  output logic [QW-1:0] r
);
  localparam int unsigned     PW  = 2 * QW;
  localparam int unsigned     K   = 2 * QW;
  localparam longint unsigned MU  = (64'd1 << K) / Q;
  localparam int unsigned     MUW = $clog2(MU + 1);
  localparam int unsigned     XW  = PW + MUW;
  localparam logic [PW-1:0]   QP  = PW'(Q);
  localparam logic [XW-1:0]   MUX = XW'(MU);

  logic [PW-1:0] prod;
  logic [XW-1:0] prod_mu;
  logic [PW-1:0] quot;
  logic [PW-1:0] rem0;
  logic [PW-1:0] rem1;
  logic [PW-1:0] rem2;

  assign prod    = PW'(a) * PW'(b);
  assign prod_mu = XW'(prod) * MUX;
  assign quot    = PW'(prod_mu >> K);
  assign rem0    = prod - quot * QP;
  // Quotient estimate is low by at most two.
  assign rem1    = (rem0 >= QP) ? rem0 - QP : rem0;
  assign rem2    = (rem1 >= QP) ? rem1 - QP : rem1;
  assign r       = QW'(rem2);
endmodule

// File: rtl/ntt_butterfly.sv
module ntt_butterfly #(
  parameter int unsigned Q  = 7681,
  parameter int unsigned QW = 14
) (
  input  logic [QW-1:0] u,
  input  logic [QW-1:0] v,
  input  logic [QW-1:0] w,
  output logic [QW-1:0] sum,
  output logic [QW-1:0] dif
);
  localparam logic [QW:0] QX = (QW + 1)'(Q);

  logic [QW-1:0] t;
  logic [QW:0]   s_raw;
  logic [QW:0]   d_wrap;

  ntt_modmul #(.Q(Q), .QW(QW)) u_mul (
    .a(v),
    .b(w),
    .r(t)
  );

  assign s_raw  = {1'b0, u} + {1'b0, t};
  assign d_wrap = {1'b0, u} + QX - {1'b0, t};
  assign sum    = (s_raw >= QX) ? QW'(s_raw - QX) : QW'(s_raw);
  assign dif    = (u >= t) ? (u - t) : QW'(d_wrap);
endmodule

// File: rtl/ntt_sched.sv
module ntt_sched #(
  parameter int unsigned N  = 256,
  parameter int unsigned AW = 7,
  parameter int unsigned SW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  output ntt_pkg::phase_e ph,
  output logic            first_stage,
  output logic [AW-1:0]   addr_x,
  output logic [AW-1:0]   addr_y,
  output logic [AW-1:0]   exp_a,
  output logic [AW-1:0]   exp_b,
  output logic            run_end
);
  import ntt_pkg::*;

  localparam logic [AW-1:0] HALF_E     = AW'(1) << (AW - 1);
  localparam logic [AW-1:0] LAST_WORD  = AW'(N / 2 - 1);
  localparam logic [AW-1:0] LAST_PAIR  = AW'(N / 4 - 1);
  localparam logic [SW-1:0] LAST_STAGE = SW'(AW);

  logic [SW-1:0] st;
  logic [AW-1:0] cnt;
  logic [SW-1:0] k;
  logic [SW-1:0] sh;
  logic [AW-1:0] bit_k;
  logic [AW-1:0] low_mask;
  logic [AW-1:0] spread;
  logic          last_cnt;
  logic          last_stage;
  logic          adv;

  // Pair position k = stage-2 (stage counted from 1); a zero is inserted there.
  assign k           = st - SW'(1);
  assign sh          = SW'(AW) - st;
  assign bit_k       = AW'(1) << k;
  assign low_mask    = bit_k - AW'(1);
  assign spread      = ((cnt & ~low_mask) << 1) | (cnt & low_mask);
  assign first_stage = (st == '0);
  assign addr_x      = first_stage ? cnt : spread;
  assign addr_y      = spread | bit_k;
  assign exp_a       = first_stage ? '0 : ((cnt & low_mask) << sh);
  assign exp_b       = exp_a | HALF_E;

  assign last_cnt   = first_stage ? (cnt == LAST_WORD) : (cnt == LAST_PAIR);
  assign last_stage = (st == LAST_STAGE);
  assign adv        = ((ph == PH_WR0) && first_stage) || (ph == PH_WR1);
  assign run_end    = adv && last_cnt && last_stage;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph  <= PH_IDLE;
      st  <= '0;
      cnt <= '0;
    end else if (adv) begin
      if (!last_cnt) begin
        cnt <= cnt + AW'(1);
        ph  <= PH_RD0;
      end else if (last_stage) begin
        ph  <= PH_IDLE;
        st  <= '0;
        cnt <= '0;
      end else begin
        st  <= st + SW'(1);
        cnt <= '0;
        ph  <= PH_RD0;
      end
    end else begin
      unique case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_RD0;
          st  <= '0;
          cnt <= '0;
        end
        PH_RD0:  ph <= first_stage ? PH_BF0 : PH_RD1;
        PH_RD1:  ph <= PH_BF0;
        PH_BF0:  ph <= first_stage ? PH_WR0 : PH_BF1;
        PH_BF1:  ph <= PH_WR0;
        PH_WR0:  ph <= PH_WR1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ntt_packed_core.sv
module ntt_packed_core #(
  parameter int unsigned N  = 256,
  parameter int unsigned Q  = 7681,
  parameter int unsigned QW = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  output logic                      busy,
  output logic                      done,
  output logic                      mem_rd_en,
  output logic                      mem_wr_en,
  output logic [$clog2(N)-2:0]      mem_addr,
  output logic [2*QW-1:0]           mem_wdata,
  input  logic [2*QW-1:0]           mem_rdata
);
  import ntt_pkg::*;

  localparam int unsigned LOGN = $clog2(N);
  localparam int unsigned AW   = LOGN - 1;
  localparam int unsigned SW   = $clog2(LOGN);
  localparam int unsigned WW   = 2 * QW;

  phase_e        ph;
  logic          first_stage;
  logic [AW-1:0] addr_x;
  logic [AW-1:0] addr_y;
  logic [AW-1:0] exp_a;
  logic [AW-1:0] exp_b;
  logic [AW-1:0] exp_sel;
  logic          run_end;

  logic [WW-1:0] x_word;
  logic [QW-1:0] y_hi;
  logic [WW-1:0] res0;
  logic [WW-1:0] res1;
  logic          done_q;

  logic [QW-1:0] op_u;
  logic [QW-1:0] op_v;
  logic [QW-1:0] tw;
  logic [QW-1:0] bf_sum;
  logic [QW-1:0] bf_dif;

  ntt_sched #(.N(N), .AW(AW), .SW(SW)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ph         (ph),
    .first_stage(first_stage),
    .addr_x     (addr_x),
    .addr_y     (addr_y),
    .exp_a      (exp_a),
    .exp_b      (exp_b),
    .run_end    (run_end)
  );

  assign exp_sel = (ph == PH_BF1) ? exp_b : exp_a;

  ntt_twiddle_rom #(.N(N), .Q(Q), .QW(QW), .EW(AW)) u_rom (
    .idx(exp_sel),
    .w  (tw)
  );

  // Operand routing: stage one pairs lanes of one word; later stages pair lanes
  // of two words (lane 0 in the first compute cycle, lane 1 in the second).
  always_comb begin
    if (ph == PH_BF1) begin
      op_u = x_word[WW-1:QW];
      op_v = y_hi;
    end else if (first_stage) begin
      op_u = mem_rdata[QW-1:0];
      op_v = mem_rdata[WW-1:QW];
    end else begin
      op_u = x_word[QW-1:0];
      op_v = mem_rdata[QW-1:0];
    end
  end

  ntt_butterfly #(.Q(Q), .QW(QW)) u_bf (
    .u  (op_u),
    .v  (op_v),
    .w  (tw),
    .sum(bf_sum),
    .dif(bf_dif)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_word <= '0;
      y_hi   <= '0;
      res0   <= '0;
      res1   <= '0;
      done_q <= 1'b0;
    end else begin
      if (ph == PH_RD1) x_word <= mem_rdata;
      if (ph == PH_BF0) begin
        y_hi <= mem_rdata[WW-1:QW];
        res0 <= {bf_dif, bf_sum};
      end
      if (ph == PH_BF1) res1 <= {bf_dif, bf_sum};
      done_q <= run_end;
    end
  end

  assign busy      = (ph != PH_IDLE);
  assign done      = done_q;
  assign mem_rd_en = (ph == PH_RD0) || (ph == PH_RD1);
  assign mem_wr_en = (ph == PH_WR0) || (ph == PH_WR1);
  assign mem_addr  = ((ph == PH_RD1) || (ph == PH_WR1)) ? addr_y : addr_x;
  assign mem_wdata = (ph == PH_WR1) ? res1 : res0;
endmodule

// File: rtl/ntt_packed_core_chk.sv
module ntt_packed_core_chk #(
  parameter int unsigned AW = 7,
  parameter int unsigned QW = 14,
  parameter int unsigned Q  = 7681
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            mem_rd_en,
  input logic            mem_wr_en,
  input logic [AW-1:0]   mem_addr,
  input logic [2*QW-1:0] mem_wdata
);
  localparam logic [QW-1:0] QL = QW'(Q);

  p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(mem_rd_en || mem_wr_en));

  p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_rd_en && (mem_addr == '0)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4 (read-to-write distance 2) and R5 (distance 4), same address.
  p_writeback_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> (($past(mem_rd_en, 2) && (mem_addr == $past(mem_addr, 2))) ||
                   ($past(mem_rd_en, 4) && (mem_addr == $past(mem_addr, 4)))));

  p_in_field_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> ((mem_wdata[QW-1:0] < QL) && (mem_wdata[2*QW-1:QW] < QL)));
endmodule

bind ntt_packed_core ntt_packed_core_chk #(.AW(AW), .QW(QW), .Q(Q)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .mem_rd_en(mem_rd_en),
  .mem_wr_en(mem_wr_en),
  .mem_addr (mem_addr),
  .mem_wdata(mem_wdata)
);

// File: tb/sim_ntt_packed_core.sv
`timescale 1ns/1ps
module sim_ntt_packed_core;
  localparam int unsigned N   = 256;
  localparam int unsigned Q   = 7681;
  localparam int unsigned QW  = 14;
  localparam int unsigned WDS = N / 2;
  localparam int RUN_LEN = 3072;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          busy, done, mem_rd_en, mem_wr_en;
  logic [6:0]    mem_addr;
  logic [27:0]   mem_wdata;
  logic [27:0]   mem_rdata;

  logic [27:0]   ram [WDS];
  int unsigned   stor [N];
  int unsigned   expv [N];
  int unsigned   pw [N];
  int unsigned   omega;

  bit            logging = 1'b0;
  int            rd_n, wr_n;
  logic [6:0]    rd_log [2048];
  logic [6:0]    wr_alog [2048];
  logic [27:0]   wr_dlog [2048];

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  ntt_packed_core u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= ram[mem_addr];
    if (mem_wr_en) ram[mem_addr] <= mem_wdata;
  end

  always @(negedge clk) begin
    if (logging) begin
      if (mem_rd_en && rd_n < 2048) begin rd_log[rd_n] = mem_addr; rd_n++; end
      if (mem_wr_en && wr_n < 2048) begin
        wr_alog[wr_n] = mem_addr; wr_dlog[wr_n] = mem_wdata; wr_n++;
      end
    end
  end

  function automatic int unsigned mm(int unsigned a, int unsigned b);
    longint unsigned p;
    p = (longint'(a) * longint'(b)) % Q;
    return int'(p);
  endfunction
  function automatic int unsigned ma(int unsigned a, int unsigned b);
    return (a + b) % Q;
  endfunction
  function automatic int unsigned ms(int unsigned a, int unsigned b);
    return (a + Q - b) % Q;
  endfunction
  function automatic int unsigned mpow(int unsigned b, int unsigned e);
    int unsigned r = 1;
    for (int i = 0; i < int'(e); i++) r = mm(r, b);
    return r;
  endfunction
  function automatic int unsigned find_omega();
    int unsigned x;
    for (int unsigned g = 2; g < Q; g++) begin
      x = mpow(g, (Q - 1) / N);
      if (mpow(x, N / 2) == Q - 1) return x;
    end
    return 0;
  endfunction
  function automatic int unsigned bitrev8(int unsigned v);
    int unsigned r = 0;
    for (int b = 0; b < 8; b++) if (((v >> b) & 1) != 0) r |= (1 << (7 - b));
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expd);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expd);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic pack_ram();
    for (int w = 0; w < int'(WDS); w++)
      ram[w] = {14'(stor[2*w+1]), 14'(stor[2*w])};
  endtask

  task automatic reference();
    int unsigned acc;
    for (int k = 0; k < int'(N); k++) begin
      acc = 0;
      for (int j = 0; j < int'(N); j++)
        acc = ma(acc, mm(stor[bitrev8(j)], pw[(j * k) % N]));
      expv[k] = acc;
    end
  endtask

  // R2 R8 R9 R10 R11 on one run
  task automatic run_check(string tag, bit poke);
    int cyc;
    int bad;
    int first_bad;
    logic [13:0] got;
    pack_ram();
    reference();
    rd_n = 0; wr_n = 0;
    logging = 1'b1;
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    chk(busy === 1'b1, "R2", {tag, " busy after start"}, busy, 1);
    cyc = 0;
    while (1) begin
      @(posedge clk); cyc++;
      @(negedge clk); start = 1'b0;
      if (poke && cyc == 100) start = 1'b1;
      if (done === 1'b1 || cyc > 5000) break;
    end
    chk(cyc == RUN_LEN, "R9", {tag, " edges to done"}, cyc, RUN_LEN);
    chk(busy === 1'b0, "R11", {tag, " busy during done"}, busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R11", {tag, " done width"}, done, 0);
    logging = 1'b0;
    chk(rd_n == 1024, "R10", {tag, " read count"}, rd_n, 1024);
    chk(wr_n == 1024, "R10", {tag, " write count"}, wr_n, 1024);
    bad = 0; first_bad = -1;
    for (int k = 0; k < int'(N); k++) begin
      got = (k < 128) ? ram[k][13:0] : ram[k - 128][27:14];
      if (int'(got) != int'(expv[k])) begin
        bad++;
        if (first_bad < 0) first_bad = k;
      end
    end
    if (first_bad < 0) first_bad = 0;
    chk(bad == 0, "R8", {tag, " spectrum coeff (first mismatch idx shown as expected-index)"},
        (first_bad < 128) ? ram[first_bad][13:0] : ram[first_bad - 128][27:14],
        expv[first_bad]);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int unsigned a0, a1, a2, a3, w64, t;
    logic [27:0] e0, e1;
    void'($urandom(32'd4242));
    omega = find_omega();
    for (int k = 0; k < int'(N); k++) pw[k] = mpow(omega, k);
    w64 = pw[64];

    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk({busy, done, mem_rd_en, mem_wr_en} === 4'b0, "R1", "outputs in reset", {busy, done, mem_rd_en, mem_wr_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, mem_rd_en, mem_wr_en} === 4'b0, "R1", "outputs after reset", {busy, done, mem_rd_en, mem_wr_en}, 0);

    for (int i = 0; i < int'(N); i++) stor[i] = 0;
    run_check("zero", 1'b0);

    for (int i = 0; i < int'(N); i++) stor[i] = 0;
    stor[0] = 1;
    run_check("delta0", 1'b0);

    for (int i = 0; i < int'(N); i++) stor[i] = 0;
    stor[1] = 1;
    run_check("delta1", 1'b0);

    for (int i = 0; i < int'(N); i++) stor[i] = Q - 1;
    run_check("allmax", 1'b0);

    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < int'(N); i++) stor[i] = $urandom % Q;
      run_check("random", 1'b0);
    end

    // Schedule and repacking checks on a random run with a stray start (R2).
    for (int i = 0; i < int'(N); i++) stor[i] = $urandom % Q;
    run_check("poke", 1'b1);

    // R4: stage one, word 0 and ordering
    chk(rd_log[0] == 7'd0, "R4", "first read addr", rd_log[0], 0);
    chk(wr_alog[5] == 7'd5, "R4", "stage1 sixth write addr", wr_alog[5], 5);
    e0 = {14'(ms(stor[0], stor[1])), 14'(ma(stor[0], stor[1]))};
    chk(wr_dlog[0] == e0, "R4", "stage1 word0 data", wr_dlog[0], e0);

    // R5: pair addresses
    chk(rd_log[128] == 7'd0 && rd_log[129] == 7'd1, "R5", "stage2 first pair",
        {rd_log[128], rd_log[129]}, {7'd0, 7'd1});
    chk(rd_log[256] == 7'd0 && rd_log[257] == 7'd2, "R5", "stage3 first pair",
        {rd_log[256], rd_log[257]}, {7'd0, 7'd2});
    chk(rd_log[1022] == 7'd63 && rd_log[1023] == 7'd127, "R5", "stage8 last pair",
        {rd_log[1022], rd_log[1023]}, {7'd63, 7'd127});
    chk(wr_alog[128] == 7'd0 && wr_alog[129] == 7'd1, "R5", "stage2 write order",
        {wr_alog[128], wr_alog[129]}, {7'd0, 7'd1});

    // R6: stage-two repacking of words 0 and 1
    a0 = ma(stor[0], stor[1]); a1 = ms(stor[0], stor[1]);
    a2 = ma(stor[2], stor[3]); a3 = ms(stor[2], stor[3]);
    e0 = {14'(ms(a0, a2)), 14'(ma(a0, a2))};
    t  = mm(a3, w64);
    e1 = {14'(ms(a1, t)), 14'(ma(a1, t))};
    chk(wr_dlog[128] == e0, "R6", "stage2 first word", wr_dlog[128], e0);
    chk(wr_dlog[129] == e1, "R6", "stage2 second word", wr_dlog[129], e1);

    summary();
    $finish;
  end
endmodule